// File: doc/BRIEF.md
# Video Port to Parallel Pixel Output Router

The router sits between a set of independent video ports and two parallel pixel outputs. Each video port supplies a 36-bit pixel word together with data-enable, horizontal sync and vertical sync. A configuration input picks which port feeds each output. The wide output carries 24 data bits and the narrow output carries 16. All outputs are registered once on the pixel clock, so data and control leave the block together, exactly one cycle after they arrive.

A new routing choice waits for the start of a frame on the newly chosen port, which means a picture is never split between two sources. Some outputs do not depend on the routing at all. Fixed auxiliary sync bundles are tapped from ports 0 and 2, and frame-sync lines copy the vertical sync of every port.

The wide output can also run in an interleaved mode. In this mode it sends each 24-bit pixel as two 12-bit beats or as three 8-bit beats. A small beat state machine with the states BEAT_IDLE, BEAT_SECOND and BEAT_THIRD controls this. It uses these transitions:
- IDLE to SECOND when a pixel is captured.
- SECOND to THIRD in three-beat mode.
- SECOND to IDLE in two-beat mode, or when the source is switched off.
- THIRD to IDLE always.

Top module: `vout_router`

## Requirements
- R1: After reset every output is 0, and both routed outputs stay disabled (all zero) until a selection has taken effect.
- R2: Output 0 presents bits [23:0] of the selected port's pixel word, with that port's data-enable, hsync and vsync, one clock after the inputs.
- R3: Output 1 presents bits [15:0] of its selected port's pixel word, with that port's data-enable, hsync and vsync, one clock after the inputs.
- R4: `route_cfg[3:0]` selects the source of output 0 and `route_cfg[7:4]` selects the source of output 1. Values 0 to 3 name ports 0 to 3. Any value of 4 or more forces that output's data, data-enable and syncs to 0, starting with the next clock.
- R5: A selection of a valid port is taken up on the clock where that port's vsync is first seen high after being low. That same clock's output already comes from the new port. Until that clock, the previous source stays routed.
- R6: `o0_aux_a` carries {vsync, hsync, de} of port 0, `o0_aux_b` carries the same of port 2, and `o1_aux` carries the same of port 0. Each is delayed one clock, whatever the routing is.
- R7: `fsync[i]` is the vsync of port i, delayed one clock, whatever the routing is.
- R8: With `ilv_mode`=1, output 0 sends each pixel in two beats. A pixel is captured when the beat machine is idle and the source's data-enable is high. Bits [23:12] go out first, then bits [11:0], each in the low 12 bits with the upper bits at 0. Data-enable is high on both beats. Input presented during the second beat is ignored.
- R9: With `ilv_mode`=2, output 0 sends each pixel as three 8-bit beats in the low byte, with bits [23:16] first, then [15:8], then [7:0]. Data-enable is high on all three beats. With `ilv_mode` 0 or 3, output 0 is direct.
- R10: Interleaving never affects output 1. Disabling output 0's source in the middle of a pixel ends the remaining beats, and the output goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vp_data | input | 144 | Pixel words, port p at bits [p*36 +: 36] |
| vp_de | input | 4 | Data-enable per port |
| vp_hs | input | 4 | Horizontal sync per port |
| vp_vs | input | 4 | Vertical sync per port |
| route_cfg | input | 8 | Source selectors: [3:0] output 0, [7:4] output 1 |
| ilv_mode | input | 2 | Output 0 beat mode: 0 direct, 1 two-beat, 2 three-beat, 3 direct |
| o0_data | output | 24 | Output 0 pixel data |
| o0_de | output | 1 | Output 0 data-enable |
| o0_hs | output | 1 | Output 0 horizontal sync |
| o0_vs | output | 1 | Output 0 vertical sync |
| o0_aux_a | output | 3 | {vs,hs,de} of port 0 |
| o0_aux_b | output | 3 | {vs,hs,de} of port 2 |
| o1_data | output | 16 | Output 1 pixel data |
| o1_de | output | 1 | Output 1 data-enable |
| o1_hs | output | 1 | Output 1 horizontal sync |
| o1_vs | output | 1 | Output 1 vertical sync |
| o1_aux | output | 3 | {vs,hs,de} of port 0 |
| fsync | output | 4 | Per-port vertical sync copies |

## Verification
The hardest condition to reach is a pending selection that waits through several active cycles of a different port. It must then switch on the single clock where the new port's vsync rises, while the other output's selection stays put. The stimulus changes the configuration first, keeps pixel traffic running with vsync low, and then raises vsync on only one target port at a time. A second hard case is cutting output 0's source off in the middle of a three-beat pixel. The bench starts a pixel in three-beat mode and writes an out-of-range selector one cycle later.

// File: rtl/vout_pkg.sv
package vout_pkg;

    localparam logic [1:0] ILV_NONE  = 2'd0;
    localparam logic [1:0] ILV_TWO   = 2'd1;
    localparam logic [1:0] ILV_THREE = 2'd2;

    typedef enum logic [1:0] {
        BEAT_IDLE   = 2'd0,
        BEAT_SECOND = 2'd1,
        BEAT_THIRD  = 2'd2
    } beat_state_t;

endpackage

// File: rtl/vout_sel_tracker.sv
module vout_sel_tracker #(
    parameter int NUM_PORTS = 4,
    parameter int SEL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     req,
    input  logic [NUM_PORTS-1:0] vs,
    output logic [SEL_W-1:0]     sel_nxt
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [SEL_W-1:0]     act_q;
    logic [NUM_PORTS-1:0] vs_prev;
    logic [NUM_PORTS-1:0] rise_vec;
    logic                 req_ok;

    assign rise_vec = vs & ~vs_prev;
    assign req_ok   = req < SEL_W'(NUM_PORTS);

    always_comb begin
        sel_nxt = act_q;
        if (!req_ok) begin
            sel_nxt = req;
        end else if (rise_vec[req[IDX_W-1:0]]) begin
            sel_nxt = req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= '1;
            vs_prev <= '0;
        end else begin
            act_q   <= sel_nxt;
            vs_prev <= vs;
        end
    end

    // R5: the active selection only ever moves to the requested value
    assert_switch_to_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> act_q == $past(req));

    // R5: moving onto a valid port needs a vsync rise of that port
    assert_switch_on_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_q) && act_q < SEL_W'(NUM_PORTS)) |->
            (($past(rise_vec) & (NUM_PORTS'(1) << act_q[IDX_W-1:0])) != '0));

endmodule

// File: rtl/vout_beat_fsm.sv
module vout_beat_fsm
    import vout_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ok,
    input  logic [1:0]       mode,
    input  logic [OUT_W-1:0] in_data,
    input  logic             in_de,
    input  logic             in_hs,
    input  logic             in_vs,
    output logic [OUT_W-1:0] o_data,
    output logic             o_de,
    output logic             o_hs,
    output logic             o_vs
);
    localparam int HALF_W  = OUT_W / 2;
    localparam int THIRD_W = OUT_W / 3;

    beat_state_t      state, state_nxt;
    logic [OUT_W-1:0] pix_q;
    logic             is_ilv;
    logic             capture;

    assign is_ilv  = (mode == ILV_TWO) || (mode == ILV_THREE);
    assign capture = (state == BEAT_IDLE) && src_ok && is_ilv && in_de;

    always_comb begin
        state_nxt = state;
        unique case (state)
            BEAT_IDLE:   state_nxt = capture ? BEAT_SECOND : BEAT_IDLE;
            BEAT_SECOND: state_nxt = (src_ok && mode == ILV_THREE) ? BEAT_THIRD : BEAT_IDLE;
            BEAT_THIRD:  state_nxt = BEAT_IDLE;
            default:     state_nxt = BEAT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BEAT_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_data <= '0;
            o_de   <= 1'b0;
            o_hs   <= 1'b0;
            o_vs   <= 1'b0;
            pix_q  <= '0;
        end else begin
            if (capture) begin
                pix_q <= in_data;
            end
            if (!src_ok) begin
                o_data <= '0;
                o_de   <= 1'b0;
                o_hs   <= 1'b0;
                o_vs   <= 1'b0;
            end else begin
                o_hs <= in_hs;
                o_vs <= in_vs;
                unique case (state)
                    BEAT_IDLE: begin
                        if (!is_ilv) begin
                            o_data <= in_data;
                            o_de   <= in_de;
                        end else if (in_de) begin
                            o_de   <= 1'b1;
                            o_data <= (mode == ILV_THREE) ? OUT_W'(in_data[OUT_W-1 -: THIRD_W])
                                                          : OUT_W'(in_data[OUT_W-1 -: HALF_W]);
                        end else begin
                            o_de   <= 1'b0;
                            o_data <= '0;
                        end
                    end
                    BEAT_SECOND: begin
                        o_de   <= 1'b1;
                        o_data <= (mode == ILV_THREE) ? OUT_W'(pix_q[2*THIRD_W-1 -: THIRD_W])
                                                      : OUT_W'(pix_q[HALF_W-1:0]);
                    end
                    BEAT_THIRD: begin
                        o_de   <= 1'b1;
                        o_data <= OUT_W'(pix_q[THIRD_W-1:0]);
                    end
                    default: begin
                        o_de   <= 1'b0;
                        o_data <= '0;
                    end
                endcase
            end
        end
    end

    // R9: a third beat is only reached from a second beat
    assert_third_after_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == BEAT_THIRD |-> $past(state) == BEAT_SECOND);

    // R8: every non-first beat of a live source raises data-enable
    assert_beat_de_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != BEAT_IDLE && src_ok) |=> o_de);

endmodule

// File: rtl/vout_router.sv
module vout_router
    import vout_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PIX_W     = 36,
    parameter int OUT0_W    = 24,
    parameter int OUT1_W    = 16,
    parameter int SEL_W     = 4,
    parameter int AUX_B_SRC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*PIX_W-1:0] vp_data,
    input  logic [NUM_PORTS-1:0]       vp_de,
    input  logic [NUM_PORTS-1:0]       vp_hs,
    input  logic [NUM_PORTS-1:0]       vp_vs,
    input  logic [2*SEL_W-1:0]         route_cfg,
    input  logic [1:0]                 ilv_mode,
    output logic [OUT0_W-1:0]          o0_data,
    output logic                       o0_de,
    output logic                       o0_hs,
    output logic                       o0_vs,
    output logic [2:0]                 o0_aux_a,
    output logic [2:0]                 o0_aux_b,
    output logic [OUT1_W-1:0]          o1_data,
    output logic                       o1_de,
    output logic                       o1_hs,
    output logic                       o1_vs,
    output logic [2:0]                 o1_aux,
    output logic [NUM_PORTS-1:0]       fsync
);
    localparam int NUM_OUTS = 2;

    logic [SEL_W-1:0]  sel_nxt [NUM_OUTS];
    logic [OUT0_W-1:0] m0_data;
    logic [OUT1_W-1:0] m1_data;
    logic              m0_de, m0_hs, m0_vs;
    logic              m1_de, m1_hs, m1_vs;
    logic              src0_ok, src1_ok;
    logic              started_q;

    genvar g;
    generate
        for (g = 0; g < NUM_OUTS; g++) begin : g_trk
            vout_sel_tracker #(
                .NUM_PORTS(NUM_PORTS),
                .SEL_W    (SEL_W)
            ) u_trk (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (route_cfg[g*SEL_W +: SEL_W]),
                .vs     (vp_vs),
                .sel_nxt(sel_nxt[g])
            );
        end
    endgenerate

    assign src0_ok = sel_nxt[0] < SEL_W'(NUM_PORTS);
    assign src1_ok = sel_nxt[1] < SEL_W'(NUM_PORTS);

    always_comb begin
        m0_data = '0; m0_de = 1'b0; m0_hs = 1'b0; m0_vs = 1'b0;
        m1_data = '0; m1_de = 1'b0; m1_hs = 1'b0; m1_vs = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel_nxt[0] == SEL_W'(p)) begin
                m0_data = vp_data[p*PIX_W +: OUT0_W];
                m0_de   = vp_de[p];
                m0_hs   = vp_hs[p];
                m0_vs   = vp_vs[p];
            end
            if (sel_nxt[1] == SEL_W'(p)) begin
                m1_data = vp_data[p*PIX_W +: OUT1_W];
                m1_de   = vp_de[p];
                m1_hs   = vp_hs[p];
                m1_vs   = vp_vs[p];
            end
        end
    end

    vout_beat_fsm #(
        .OUT_W(OUT0_W)
    ) u_beat0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_ok (src0_ok),
        .mode   (ilv_mode),
        .in_data(m0_data),
        .in_de  (m0_de),
        .in_hs  (m0_hs),
        .in_vs  (m0_vs),
        .o_data (o0_data),
        .o_de   (o0_de),
        .o_hs   (o0_hs),
        .o_vs   (o0_vs)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o1_data   <= '0;
            o1_de     <= 1'b0;
            o1_hs     <= 1'b0;
            o1_vs     <= 1'b0;
            o0_aux_a  <= '0;
            o0_aux_b  <= '0;
            o1_aux    <= '0;
            fsync     <= '0;
            started_q <= 1'b0;
        end else begin
            o1_data   <= src1_ok ? m1_data : '0;
            o1_de     <= src1_ok & m1_de;
            o1_hs     <= src1_ok & m1_hs;
            o1_vs     <= src1_ok & m1_vs;
            o0_aux_a  <= {vp_vs[0], vp_hs[0], vp_de[0]};
            o0_aux_b  <= {vp_vs[AUX_B_SRC], vp_hs[AUX_B_SRC], vp_de[AUX_B_SRC]};
            o1_aux    <= {vp_vs[0], vp_hs[0], vp_de[0]};
            fsync     <= vp_vs;
            started_q <= 1'b1;
        end
    end

    // R7: frame-sync lines follow every port's vsync one clock later
    assert_fsync_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> fsync == $past(vp_vs));

    // R4: an out-of-range selector leaves output 1 silent
    assert_out1_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(sel_nxt[1]) >= SEL_W'(NUM_PORTS)) |-> (!o1_de && o1_data == '0));

    // R6: the port-2 bundle ignores routing entirely
    assert_aux_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> o0_aux_b == $past({vp_vs[AUX_B_SRC], vp_hs[AUX_B_SRC], vp_de[AUX_B_SRC]}));

endmodule

// File: tb/test_vout_router.sv
module test_vout_router;

    localparam int NP = 4;
    localparam int PW = 36;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*PW-1:0] vp_data = '0;
    logic [NP-1:0]   vp_de = '0, vp_hs = '0, vp_vs = '0;
    logic [7:0]      route_cfg = 8'hFF;
    logic [1:0]      ilv_mode = 2'd0;
    logic [23:0]     o0_data;
    logic            o0_de, o0_hs, o0_vs;
    logic [2:0]      o0_aux_a, o0_aux_b, o1_aux;
    logic [15:0]     o1_data;
    logic            o1_de, o1_hs, o1_vs;
    logic [NP-1:0]   fsync;

    vout_router i_vout_router (
        .clk(clk), .rst_n(rst_n), .vp_data(vp_data), .vp_de(vp_de), .vp_hs(vp_hs),
        .vp_vs(vp_vs), .route_cfg(route_cfg), .ilv_mode(ilv_mode),
        .o0_data(o0_data), .o0_de(o0_de), .o0_hs(o0_hs), .o0_vs(o0_vs),
        .o0_aux_a(o0_aux_a), .o0_aux_b(o0_aux_b),
        .o1_data(o1_data), .o1_de(o1_de), .o1_hs(o1_hs), .o1_vs(o1_vs),
        .o1_aux(o1_aux), .fsync(fsync)
    );

    always #4 clk = ~clk;

    typedef logic [24+3+16+3+9+4-1:0] obs_t;

    obs_t  exp_q [$];
    string tag_q [$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    // reference view built from the requirements
    logic [3:0]  b_sel [2] = '{4'hF, 4'hF};
    logic [3:0]  b_vsprev = '0;
    int          b_beat = 0;
    logic [23:0] b_pix = '0;
    int          cnt = 0;

    function automatic obs_t observe();
        return {o0_data, o0_de, o0_hs, o0_vs, o1_data, o1_de, o1_hs, o1_vs,
                o0_aux_a, o0_aux_b, o1_aux, fsync};
    endfunction

    task automatic cyc(input logic [7:0] cfg, input logic [1:0] mode, input logic [3:0] de,
                       input logic [3:0] hs, input logic [3:0] vs, input string tag);
        logic [23:0] d0; logic e0, h0, v0;
        logic [15:0] d1; logic e1, h1, v1;
        logic [3:0]  nx [2];
        logic [23:0] p;
        bit          ilv;
        @(negedge clk);
        cnt++;
        for (int k = 0; k < NP; k++)
            vp_data[k*PW +: PW] = {4'hA, 8'(k * 17 + cnt), 24'(cnt * 40503 + k * 7919 + 24'h3C0000)};
        route_cfg = cfg; ilv_mode = mode; vp_de = de; vp_hs = hs; vp_vs = vs;
        for (int o = 0; o < 2; o++) begin
            logic [3:0] rq;
            rq = cfg[o*4 +: 4];
            nx[o] = b_sel[o];
            if (rq > 3) nx[o] = rq;
            else if (vs[rq[1:0]] && !b_vsprev[rq[1:0]]) nx[o] = rq;
        end
        ilv = (mode == 2'd1) || (mode == 2'd2);
        d0 = '0; e0 = 0; h0 = 0; v0 = 0;
        if (nx[0] > 3) begin
            b_beat = 0;
        end else begin
            p  = vp_data[nx[0]*PW +: 24];
            h0 = hs[nx[0][1:0]]; v0 = vs[nx[0][1:0]];
            if (b_beat == 0) begin
                if (!ilv) begin
                    d0 = p; e0 = de[nx[0][1:0]];
                end else if (de[nx[0][1:0]]) begin
                    e0 = 1; b_pix = p; b_beat = 1;
                    d0 = (mode == 2'd2) ? {16'h0, p[23:16]} : {12'h0, p[23:12]};
                end
            end else if (b_beat == 1) begin
                e0 = 1;
                if (mode == 2'd2) begin d0 = {16'h0, b_pix[15:8]}; b_beat = 2; end
                else begin d0 = {12'h0, b_pix[11:0]}; b_beat = 0; end
            end else begin
                e0 = 1; d0 = {16'h0, b_pix[7:0]}; b_beat = 0;
            end
        end
        d1 = '0; e1 = 0; h1 = 0; v1 = 0;
        if (nx[1] <= 3) begin
            d1 = vp_data[nx[1]*PW +: 16];
            e1 = de[nx[1][1:0]]; h1 = hs[nx[1][1:0]]; v1 = vs[nx[1][1:0]];
        end
        exp_q.push_back({d0, e0, h0, v0, d1, e1, h1, v1,
                         {vs[0], hs[0], de[0]}, {vs[2], hs[2], de[2]}, {vs[0], hs[0], de[0]}, vs});
        tag_q.push_back(tag);
        b_sel[0] = nx[0]; b_sel[1] = nx[1]; b_vsprev = vs;
    endtask

    // monitor: compare one expected item per clock
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            obs_t  e;
            obs_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = observe();
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", t, a, e);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++; // R1 outputs quiet in reset
        if (observe() !== '0) begin
            bad++; $display("FAIL R1: actual=%h expected=0", observe());
        end
        rst_n = 1'b1;
        // R1 routed outputs disabled until a selection lands
        cyc(8'h10, 0, 4'hF, 4'h0, 4'h0, "R1");
        cyc(8'h10, 0, 4'hF, 4'h5, 4'h0, "R1");
        // R5 vsync rise on ports 0 and 1 takes the routing
        cyc(8'h10, 0, 4'h0, 4'h0, 4'b0011, "R5");
        cyc(8'h10, 0, 4'hF, 4'h0, 4'b0011, "R2");
        cyc(8'h10, 0, 4'hF, 4'h3, 4'h0, "R2");
        cyc(8'h10, 0, 4'h5, 4'hA, 4'h0, "R3");
        cyc(8'h10, 0, 4'hA, 4'h0, 4'h0, "R3");
        cyc(8'h10, 0, 4'h0, 4'hF, 4'h0, "R2");
        // R5 new request waits for the new port's vsync
        cyc(8'h23, 0, 4'hF, 4'h0, 4'h0, "R5");
        cyc(8'h23, 0, 4'hF, 4'hC, 4'b0011, "R5");
        cyc(8'h23, 0, 4'hF, 4'h0, 4'b1000, "R5");
        cyc(8'h23, 0, 4'h9, 4'h0, 4'b1000, "R2");
        cyc(8'h23, 0, 4'hF, 4'h0, 4'b0000, "R5");
        cyc(8'h23, 0, 4'hF, 4'h4, 4'b0100, "R3");
        cyc(8'h23, 0, 4'h6, 4'h0, 4'b0000, "R3");
        // R6 and R7 fixed taps under varied patterns
        cyc(8'h23, 0, 4'b0101, 4'b0001, 4'b0100, "R6");
        cyc(8'h23, 0, 4'b0100, 4'b0101, 4'b0001, "R6");
        cyc(8'h23, 0, 4'b0001, 4'b0000, 4'b1111, "R7");
        cyc(8'h23, 0, 4'b0000, 4'b0000, 4'b1010, "R7");
        // R4 out-of-range selectors silence the output
        cyc(8'h2F, 0, 4'hF, 4'hF, 4'h0, "R4");
        cyc(8'h24, 0, 4'hF, 4'hF, 4'hF, "R4");
        cyc(8'h53, 0, 4'hF, 4'hF, 4'h0, "R4");
        cyc(8'hF3, 0, 4'hF, 4'hF, 4'hF, "R4");
        cyc(8'h13, 0, 4'hF, 4'h0, 4'h0, "R4");
        cyc(8'h13, 0, 4'hF, 4'h0, 4'b1010, "R5");
        // R8 two-beat interleave on output 0 (port 3), output 1 on port 1
        cyc(8'h13, 1, 4'hF, 4'h0, 4'h0, "R8");
        cyc(8'h13, 1, 4'h0, 4'h0, 4'h0, "R8");
        cyc(8'h13, 1, 4'h0, 4'h0, 4'h0, "R8");
        cyc(8'h13, 1, 4'hF, 4'h8, 4'h0, "R8");
        cyc(8'h13, 1, 4'hF, 4'h0, 4'h0, "R10");
        cyc(8'h13, 1, 4'hF, 4'h0, 4'h0, "R8");
        // R9 three-beat interleave
        cyc(8'h13, 2, 4'hF, 4'h0, 4'h0, "R9");
        cyc(8'h13, 2, 4'h0, 4'h0, 4'h0, "R9");
        cyc(8'h13, 2, 4'hF, 4'h0, 4'h0, "R9");
        cyc(8'h13, 2, 4'hF, 4'h0, 4'h0, "R10");
        cyc(8'h13, 2, 4'h0, 4'h0, 4'h0, "R9");
        cyc(8'h13, 2, 4'h0, 4'h0, 4'h0, "R9");
        cyc(8'h13, 3, 4'hF, 4'h0, 4'h0, "R9");
        // R10 cut the source mid-pixel
        cyc(8'h13, 2, 4'hF, 4'h0, 4'h0, "R10");
        cyc(8'h1F, 2, 4'hF, 4'h0, 4'h0, "R10");
        cyc(8'h1F, 2, 4'hF, 4'h0, 4'h0, "R10");
        cyc(8'h13, 2, 4'h0, 4'h0, 4'b1000, "R10");
        cyc(8'h13, 2, 4'hF, 4'h0, 4'h0, "R9");
        cyc(8'h13, 0, 4'h0, 4'h0, 4'h0, "R9");
        cyc(8'h13, 0, 4'h0, 4'h0, 4'h0, "R2");
        cyc(8'h13, 0, 4'h0, 4'h0, 4'h0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule